// File: doc/BRIEF.md
# Indexed and Indirect Effective Address Generator

This unit turns an addressing-mode code, a 16-bit operand field and the two 8-bit index registers into a 16-bit effective memory address. The direct modes (absolute, absolute plus an index, zero page, zero page plus an index) are resolved in a single cycle. The three pointer modes fetch a little-endian 16-bit pointer over a byte-wide read port and then return that pointer, with or without the Y index added. Pointer modes take two handshaked reads. The caller pulses `start` while `busy` is low and then waits for either `done` with `addr`, or `illegal`.

Codes that name operand-only modes produce no memory address, so they are rejected. These are immediate, accumulator, implied and relative, and all other unassigned codes are rejected with them. A pre-indexed pointer that sits at zero-page location 0xFF has its high byte fetched from 0x0100. That result is marked with a separate flag.

Top module: `ea_gen`

## Requirements
- R1: The mode codes are 0 absolute, 1 absolute+X, 2 absolute+Y, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 pre-indexed indirect, 7 post-indexed indirect and 8 absolute indirect. In absolute mode, `done` pulses in the cycle after the `start` cycle, with `addr` equal to the operand.
- R2: Absolute+X and absolute+Y give the operand plus the zero-extended index, modulo 2^16, with `done` in the cycle after `start`.
- R3: Zero page gives {0x00, operand[7:0]}. Zero page+X and zero page+Y give {0x00, (operand[7:0] + index) mod 256}, so the result never leaves page zero.
- R4: Pre-indexed indirect reads the low byte at {0x00, (operand[7:0] + X) mod 256} and the high byte at the next address. It returns {high, low}, with `done` in the cycle after the second read completes.
- R5: When the pre-indexed location is 0xFF, the high byte is read from 0x0100, and `ptr_split` is high together with `done`. Otherwise `ptr_split` is low.
- R6: Post-indexed indirect reads the pointer at {0x00, operand[7:0]} and at the next 16-bit address. It returns the pointer plus the zero-extended Y, modulo 2^16.
- R7: Absolute indirect reads the pointer at the operand and at the operand + 1, with carry through all 16 bits, so 0xFFFF is followed by 0x0000.
- R8: Codes 9 to 15 assert `illegal` for exactly one cycle, the cycle after `start`. They raise no `done` and issue no read.
- R9: `rd_req` stays high with a stable `rd_addr` until `rd_valid` is seen. The low byte is always requested first.
- R10: A `start` while `busy` is high is ignored. It produces no extra result and does not change the result in progress.
- R11: After reset, `done`, `illegal`, `rd_req`, `busy` and `ptr_split` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a translation (taken only when not busy) |
| mode | input | 4 | Addressing-mode code |
| operand | input | 16 | Operand field; bits 7:0 serve as the 8-bit operand |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| busy | output | 1 | A pointer fetch is in progress |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle strobe: `addr` is valid |
| addr | output | 16 | Effective address |
| ptr_split | output | 1 | Pre-indexed pointer straddled page zero (valid with `done`) |
| illegal | output | 1 | One-cycle strobe: mode has no memory address |

## Verification
The bench targets the wrap boundaries. In zero page+X, 0xF0 + 0x20 must give 0x0010; a design that carried into the high byte would return 0x0110. Absolute+X from 0xFFF0 must wrap to 0x0010. The pre-indexed sum 0x80 + 0x90 must select location 0x10.

For the split pointer, the bench checks the exact read addresses 0x00FF and then 0x0100, plus the flag. This catches a design that wraps the high-byte fetch back to 0x0000, or one that never flags the split. Absolute indirect at 0xFFFF must read 0x0000 second.

The bench also checks three ordering errors: putting Y on the wrong side of the pointer load, swapping the byte order, or requesting the high byte first. Each of these shows up as a wrong address. Read latencies of zero and three cycles are applied, so a design that drops the request before `rd_valid` misses data.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic [AW-1:0] operand,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic [AW-1:0] addr,
  output logic          ptr_split,
  output logic          illegal
);
  localparam int PW = AW - DW;
  localparam logic [MW-1:0] M_ABS  = MW'(0);
  localparam logic [MW-1:0] M_ABSX = MW'(1);
  localparam logic [MW-1:0] M_ABSY = MW'(2);
  localparam logic [MW-1:0] M_ZP   = MW'(3);
  localparam logic [MW-1:0] M_ZPX  = MW'(4);
  localparam logic [MW-1:0] M_ZPY  = MW'(5);
  localparam logic [MW-1:0] M_PRE  = MW'(6);
  localparam logic [MW-1:0] M_POST = MW'(7);
  localparam logic [MW-1:0] M_IND  = MW'(8);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} state_t;

  state_t        st;
  logic [AW-1:0] ptr_loc;
  logic [DW-1:0] lo_byte;
  logic          post_q, split_q;
  logic [AW-1:0] addr_q;
  logic          done_q, ill_q;

  logic [DW-1:0] op8;
  logic [AW-1:0] xz, yz;
  logic [AW-1:0] direct_ea, ptr_start;
  logic          is_direct, is_ptr;

  assign op8 = operand[DW-1:0];
  assign xz  = {{PW{1'b0}}, idx_x};
  assign yz  = {{PW{1'b0}}, idx_y};

  always_comb begin
    direct_ea = '0;
    ptr_start = '0;
    is_direct = 1'b0;
    is_ptr    = 1'b0;
    case (mode)
      M_ABS:  begin is_direct = 1'b1; direct_ea = operand; end
      M_ABSX: begin is_direct = 1'b1; direct_ea = operand + xz; end
      M_ABSY: begin is_direct = 1'b1; direct_ea = operand + yz; end
      M_ZP:   begin is_direct = 1'b1; direct_ea = {{PW{1'b0}}, op8}; end
      M_ZPX:  begin is_direct = 1'b1; direct_ea = {{PW{1'b0}}, DW'(op8 + idx_x)}; end
      M_ZPY:  begin is_direct = 1'b1; direct_ea = {{PW{1'b0}}, DW'(op8 + idx_y)}; end
      M_PRE:  begin is_ptr = 1'b1; ptr_start = {{PW{1'b0}}, DW'(op8 + idx_x)}; end
      M_POST: begin is_ptr = 1'b1; ptr_start = {{PW{1'b0}}, op8}; end
      M_IND:  begin is_ptr = 1'b1; ptr_start = operand; end
      default: ;
    endcase
  end

  assign busy    = (st != S_IDLE);
  assign rd_req  = busy;
  assign rd_addr = (st == S_HI) ? ptr_loc + AW'(1) : ptr_loc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr_loc <= '0;
      lo_byte <= '0;
      post_q  <= 1'b0;
      split_q <= 1'b0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (is_direct) begin
            addr_q  <= direct_ea;
            split_q <= 1'b0;
            done_q  <= 1'b1;
          end else if (is_ptr) begin
            ptr_loc <= ptr_start;
            post_q  <= (mode == M_POST);
            split_q <= (mode == M_PRE) && (ptr_start == {{PW{1'b0}}, {DW{1'b1}}});
            st      <= S_LO;
          end else begin
            ill_q <= 1'b1;
          end
        end
        S_LO: if (rd_valid) begin
          lo_byte <= rd_data;
          st      <= S_HI;
        end
        S_HI: if (rd_valid) begin
          addr_q <= {rd_data, lo_byte} + (post_q ? yz : '0);
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign illegal   = ill_q;
  assign addr      = addr_q;
  assign ptr_split = done_q & split_q;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [MW-1:0] mode,
  input logic          busy,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          done,
  input logic          ptr_split,
  input logic          illegal
);
  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && illegal));

  assert_illegal_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(start && !busy && (mode > MW'(8))));

  assert_illegal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !rd_req);

  assert_split_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_split |-> done);

  assert_req_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .DW(DW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .done(done),
  .ptr_split(ptr_split), .illegal(illegal)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] operand = '0;
  logic [7:0]  idx_x = '0, idx_y = '0;
  logic        busy, rd_req, done, ptr_split, illegal;
  logic [15:0] rd_addr, addr;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;

  int checks = 0, errors = 0;
  int lat = 0, lcnt = 0;
  int cyc = 0;
  bit finished = 0;

  logic [17:0] exp_q[$];
  logic [15:0] rd_q[$];

  always #2 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .operand(operand),
    .idx_x(idx_x), .idx_y(idx_y), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .addr(addr),
    .ptr_split(ptr_split), .illegal(illegal)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (rd_req && !rd_valid) begin
      if (lcnt >= lat) begin
        rd_valid <= 1'b1;
        rd_data  <= mb(rd_addr);
        lcnt     <= 0;
      end else lcnt <= lcnt + 1;
    end else rd_valid <= 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (rd_q.size() == 0) check("R9 unexpected read", {16'h0, rd_addr}, 32'hFFFFFFFF);
        else check("R9 read address order", {16'h0, rd_addr}, {16'h0, rd_q.pop_front()});
      end
      if (done || illegal) begin
        if (exp_q.size() == 0) check("R10 unexpected result", {13'h0, ptr_split, illegal, done, addr}, 32'hFFFFFFFF);
        else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          if (e[16]) check("R8 illegal outcome", {30'h0, illegal, done}, 32'h2);
          else check("R1-7 result", {14'h0, ptr_split, done, addr}, {14'h0, e[17], 1'b1, e[15:0]});
        end
      end
    end
  end

  task automatic go(input logic [3:0] m, input logic [15:0] op, input logic [7:0] x, input logic [7:0] y);
    logic [15:0] e, loc, p;
    logic        sp;
    sp = 1'b0;
    e  = '0;
    case (m)
      4'd0: e = op;
      4'd1: e = op + {8'h0, x};
      4'd2: e = op + {8'h0, y};
      4'd3: e = {8'h0, op[7:0]};
      4'd4: e = {8'h0, 8'(op[7:0] + x)};
      4'd5: e = {8'h0, 8'(op[7:0] + y)};
      4'd6, 4'd7, 4'd8: begin
        loc = (m == 4'd6) ? {8'h0, 8'(op[7:0] + x)} : (m == 4'd7) ? {8'h0, op[7:0]} : op;
        rd_q.push_back(loc);
        rd_q.push_back(loc + 16'd1);
        p = {mb(loc + 16'd1), mb(loc)};
        e = (m == 4'd7) ? p + {8'h0, y} : p;
        sp = (m == 4'd6) && (loc == 16'h00FF);
      end
      default: ;
    endcase
    exp_q.push_back({sp, (m > 4'd8), e});
    mode = m; operand = op; idx_x = x; idx_y = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 done at reset", {31'h0, done}, 0);
    check("R11 illegal at reset", {31'h0, illegal}, 0);
    check("R11 rd_req at reset", {31'h0, rd_req}, 0);
    check("R11 busy at reset", {31'h0, busy}, 0);
    check("R11 ptr_split at reset", {31'h0, ptr_split}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    go(4'd0, 16'h1234, 8'h11, 8'h22);   // R1
    go(4'd1, 16'hFFF0, 8'h20, 8'h00);   // R2 wrap
    go(4'd2, 16'h1000, 8'h00, 8'hFF);   // R2
    go(4'd3, 16'h77AB, 8'h01, 8'h01);   // R3
    go(4'd4, 16'h12F0, 8'h20, 8'h00);   // R3 page-zero wrap
    go(4'd5, 16'h0080, 8'h00, 8'h7F);   // R3
    for (int l = 0; l < 2; l++) begin
      lat = (l == 0) ? 0 : 3;           // R9 latency variation
      go(4'd6, 16'h0010, 8'h05, 8'h00); // R4
      go(4'd6, 16'h0080, 8'h90, 8'h00); // R4 index wrap
      go(4'd6, 16'h00F0, 8'h0F, 8'h00); // R5 split
      go(4'd7, 16'h0040, 8'h33, 8'hFF); // R6
      go(4'd7, 16'h00FF, 8'h00, 8'h01); // R6 no split flag
      go(4'd8, 16'h2000, 8'h00, 8'h00); // R7
      go(4'd8, 16'hFFFF, 8'h00, 8'h00); // R7 carry wrap
    end
    for (int m = 9; m < 16; m++) go(4'(m), 16'h00AA, 8'h01, 8'h02); // R8

    // R10: start while busy is ignored
    lat = 2;
    exp_q.push_back({1'b0, 1'b0, 16'h0000});
    begin
      logic [15:0] p;
      rd_q.push_back(16'h3000);
      rd_q.push_back(16'h3001);
      p = {mb(16'h3001), mb(16'h3000)};
      exp_q[exp_q.size()-1] = {2'b00, p};
    end
    mode = 4'd8; operand = 16'h3000; start = 1'b1;
    @(negedge clk);
    mode = 4'd0; operand = 16'hBEEF;
    @(negedge clk);
    mode = 4'd9;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);

    check("R10 scoreboard drained", exp_q.size(), 0);
    check("R8 no stray reads", rd_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule